// File: doc/BRIEF.md
# Multi-Rate TDM Time-Slot Switch

This block is a non-blocking time-slot interchange for serial time-division highways. It has `NS_IN` serial inputs and `NS_OUT` serial outputs. Every 125 µs frame it collects each 8-bit channel from every input into a double-buffered data store. During the following frame it plays the bytes back onto the output slots. A connection store holds one word per output slot. The word names the source stream and the source channel, marks the slot as undriven if required, and supplies one control bit.

All timing comes from one fast master clock, 16 × `CH_HI` clocks per frame. The inputs and the outputs are each split into a lower half and an upper half. Each of the four groups takes its own rate code, so it runs at 2, 4 or 8 clocks per bit (32, 64 or 128 channels per frame when `CH_HI` = 128). When all four codes are equal, the block behaves as a single-rate switch.

A one-clock frame pulse restarts the frame. A serial control output carries the control bits of all connection words, one bit per clock.

Top module: `tdm_tsi_switch`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `ser_oe` and `ctl_out` are all 0 and the frame counter is held at 0.
- R2: A high `frame_pulse` sampled at a clock edge makes the next cycle slot 0 of a new frame. Without a pulse, the counter steps by one per clock and wraps after 16·`CH_HI` clocks, and each wrap starts a new frame.
- R3: The rate code of each group sets its clocks per bit: code 0 gives 8, code 1 gives 4, and code 2 or 3 gives 2. Streams below `NS/2` use the `_lo` code and the others use the `_hi` code.
- R4: Each channel is 8 bits, sent MSB first. An input bit is sampled on the last clock of its bit period. Output bit number k of a frame is valid during the whole of frame-counter cycles k·P to k·P+P−1, where P is the clocks per bit.
- R5: Output stream o, channel c, in frame N carries the byte that arrived in frame N−1 on the source stream and channel held in connection word (o, c).
- R6: When the undriven flag of connection word (o, c) is 1, `ser_oe[o]` is 0 for the whole of that slot.
- R7: When both `drive_pin` and `drive_cfg` are 0, every `ser_oe` bit is 0. When either is 1, `ser_oe[o]` is 1 in every slot whose word does not set the undriven flag.
- R8: In frame cycle k, `ctl_out` carries the control bit of connection word (stream k mod `NS_OUT`, channel k div `NS_OUT`) when k < `NS_OUT`·`CH_HI`, and 0 otherwise.
- R9: A cycle with `cm_we` high stores `cm_src_stream`, `cm_src_chan`, `cm_hiz` and `cm_ctl` as connection word (`cm_stream`, `cm_chan`). The word takes effect for outputs from the next cycle.
- R10: An output slot at the very start of a frame may take the last channel of the previous frame, which completes on the final clock of that frame, and still receives the complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (16·CH_HI clocks per frame) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | One-clock frame restart |
| rate_in_lo | input | 2 | Rate code, lower input half |
| rate_in_hi | input | 2 | Rate code, upper input half |
| rate_out_lo | input | 2 | Rate code, lower output half |
| rate_out_hi | input | 2 | Rate code, upper output half |
| drive_pin | input | 1 | Global output drive enable |
| drive_cfg | input | 1 | Configured output drive enable, ORed with drive_pin |
| ser_in | input | NS_IN | Serial input streams |
| cm_we | input | 1 | Connection word write strobe |
| cm_stream | input | log2(NS_OUT) | Output stream of the word written |
| cm_chan | input | log2(CH_HI) | Output channel of the word written |
| cm_src_stream | input | log2(NS_IN) | Source stream field |
| cm_src_chan | input | log2(CH_HI) | Source channel field |
| cm_hiz | input | 1 | Undriven flag field |
| cm_ctl | input | 1 | Control bit field |
| ser_out | output | NS_OUT | Serial output data |
| ser_oe | output | NS_OUT | Per-stream output enable, 1 = drive |
| ctl_out | output | 1 | Serial control bitstream |

## Verification
The assertions assume three things about the inputs. After the first pulse, `frame_pulse` comes only on the last cycle of a frame or not at all. Rate codes change only together with a frame restart. Connection source fields name a channel that exists at the source stream's rate. The bench holds rates and drive enables fixed for each run. It writes every connection word before a run and then restarts the frame with a pulse. Between the arithmetic source mapping and its wrap against each source stream's own channel count, the source channel stays in range. Data is compared only from the second frame of a run, so every compared byte was received under the current settings.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic [1:0] {
    RATE_2M     = 2'd0,
    RATE_4M     = 2'd1,
    RATE_8M     = 2'd2,
    RATE_8M_ALT = 2'd3
  } rate_code_e;

  // log2 of master clocks per serial bit for a rate code
  function automatic logic [1:0] rate_shift(input logic [1:0] code);
    logic [1:0] sh;
    case (code)
      RATE_2M: sh = 2'd3;
      RATE_4M: sh = 2'd2;
      default: sh = 2'd1;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp,
  output logic [CW-1:0] cnt_q,
  output logic          par_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          par_nxt
);

  always_comb begin
    if (fp) begin
      cnt_nxt = '0;
      par_nxt = ~par_q;
    end else begin
      cnt_nxt = cnt_q + CW'(1);
      par_nxt = (&cnt_q) ? ~par_q : par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      par_q <= par_nxt;
    end
  end

endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store
  import tsi_pkg::*;
#(
  parameter int NS_IN  = 4,
  parameter int NS_OUT = 4,
  parameter int CH_HI  = 128,
  localparam int SIW = $clog2(NS_IN),
  localparam int CHW = $clog2(CH_HI),
  localparam int CW  = CHW + 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CW-1:0]                 cnt_q,
  input  logic                          par_q,
  input  logic [1:0]                    rate_lo,
  input  logic [1:0]                    rate_hi,
  input  logic [NS_IN-1:0]              ser_in,
  input  logic                          rd_bank,
  input  logic [NS_OUT-1:0][SIW-1:0]    rd_stream,
  input  logic [NS_OUT-1:0][CHW-1:0]    rd_chan,
  output logic [NS_OUT-1:0][7:0]        rd_data
);

  logic [NS_IN-1:0]           wr_en;
  logic [NS_IN-1:0][CHW-1:0]  wr_ch;
  logic [NS_IN-1:0][7:0]      wr_byte;

  logic [7:0] mem [2][NS_IN][CH_HI];

  for (genvar i = 0; i < NS_IN; i++) begin : g_in
    logic [1:0]    lg;
    logic [2:0]    lg3;
    logic [CW-1:0] mask;
    logic          smp;
    logic [2:0]    bit_i;
    logic [6:0]    sh_q;
    logic [6:0]    sh_d;

    assign lg    = (i < NS_IN / 2) ? rate_shift(rate_lo) : rate_shift(rate_hi);
    assign lg3   = {1'b0, lg};
    assign mask  = (CW'(1) << lg) - CW'(1);
    assign smp   = (cnt_q & mask) == mask;
    assign bit_i = 3'(cnt_q >> lg);

    always_comb begin
      sh_d = sh_q;
      if (smp) sh_d = {sh_q[5:0], ser_in[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign wr_en[i]   = smp && (bit_i == 3'd7);
    assign wr_ch[i]   = CHW'(cnt_q >> (lg3 + 3'd3));
    assign wr_byte[i] = {sh_q, ser_in[i]};
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NS_IN; i++) begin
      if (wr_en[i]) mem[par_q][i][wr_ch[i]] <= wr_byte[i];
    end
  end

  for (genvar o = 0; o < NS_OUT; o++) begin : g_rd
    logic [7:0] raw;
    logic       hit;
    assign raw = mem[rd_bank][rd_stream[o]][rd_chan[o]];
    assign hit = (rd_bank == par_q) && wr_en[rd_stream[o]] &&
                 (wr_ch[rd_stream[o]] == rd_chan[o]);
    assign rd_data[o] = hit ? wr_byte[rd_stream[o]] : raw;
  end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NS_IN  = 4,
  parameter int NS_OUT = 4,
  parameter int CH_HI  = 128,
  localparam int SIW = $clog2(NS_IN),
  localparam int SOW = $clog2(NS_OUT),
  localparam int CHW = $clog2(CH_HI),
  localparam int CW  = CHW + 4
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [SOW-1:0]              wr_stream,
  input  logic [CHW-1:0]              wr_chan,
  input  logic [SIW-1:0]              wr_src_st,
  input  logic [CHW-1:0]              wr_src_ch,
  input  logic                        wr_hiz,
  input  logic                        wr_ctl,
  input  logic [NS_OUT-1:0][CHW-1:0]  rd_chan,
  input  logic [CW-1:0]               ctl_idx,
  output logic [NS_OUT-1:0][SIW-1:0]  rd_src_st,
  output logic [NS_OUT-1:0][CHW-1:0]  rd_src_ch,
  output logic [NS_OUT-1:0]           rd_hiz,
  output logic                        ctl_bit
);

  logic [SIW-1:0] m_st  [NS_OUT][CH_HI];
  logic [CHW-1:0] m_ch  [NS_OUT][CH_HI];
  logic           m_hiz [NS_OUT][CH_HI];
  logic           m_ctl [NS_OUT][CH_HI];

  always_ff @(posedge clk) begin
    if (we) begin
      m_st[wr_stream][wr_chan]  <= wr_src_st;
      m_ch[wr_stream][wr_chan]  <= wr_src_ch;
      m_hiz[wr_stream][wr_chan] <= wr_hiz;
      m_ctl[wr_stream][wr_chan] <= wr_ctl;
    end
  end

  for (genvar o = 0; o < NS_OUT; o++) begin : g_port
    assign rd_src_st[o] = m_st[o][rd_chan[o]];
    assign rd_src_ch[o] = m_ch[o][rd_chan[o]];
    assign rd_hiz[o]    = m_hiz[o][rd_chan[o]];
  end

  logic [SOW-1:0] c_st;
  logic [CHW-1:0] c_ch;
  logic           c_in_range;

  assign c_st       = ctl_idx[SOW-1:0];
  assign c_ch       = ctl_idx[SOW +: CHW];
  assign c_in_range = (ctl_idx >> (SOW + CHW)) == '0;
  assign ctl_bit    = c_in_range & m_ctl[c_st][c_ch];

endmodule

// File: rtl/tsi_tx_serial.sv
module tsi_tx_serial
  import tsi_pkg::*;
#(
  parameter int NS_OUT = 4,
  parameter int CH_HI  = 128,
  localparam int CHW = $clog2(CH_HI),
  localparam int CW  = CHW + 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CW-1:0]               cnt_nxt,
  input  logic [1:0]                  rate_lo,
  input  logic [1:0]                  rate_hi,
  input  logic                        drive_en,
  input  logic [NS_OUT-1:0][7:0]      byte_in,
  input  logic [NS_OUT-1:0]           hiz_in,
  input  logic                        ctl_in,
  output logic [NS_OUT-1:0][CHW-1:0]  slot_chan,
  output logic [NS_OUT-1:0]           ser_out,
  output logic [NS_OUT-1:0]           ser_oe,
  output logic                        ctl_out
);

  logic [NS_OUT-1:0] so_d;
  logic [NS_OUT-1:0] oe_d;

  for (genvar o = 0; o < NS_OUT; o++) begin : g_out
    logic [1:0] lg;
    logic [2:0] lg3;
    logic [2:0] bit_n;

    assign lg           = (o < NS_OUT / 2) ? rate_shift(rate_lo) : rate_shift(rate_hi);
    assign lg3          = {1'b0, lg};
    assign bit_n        = 3'(cnt_nxt >> lg);
    assign slot_chan[o] = CHW'(cnt_nxt >> (lg3 + 3'd3));
    assign so_d[o]      = byte_in[o][3'd7 - bit_n];
    assign oe_d[o]      = drive_en & ~hiz_in[o];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out <= '0;
      ser_oe  <= '0;
      ctl_out <= 1'b0;
    end else begin
      ser_out <= so_d;
      ser_oe  <= oe_d;
      ctl_out <= ctl_in;
    end
  end

endmodule

// File: rtl/tdm_tsi_switch.sv
module tdm_tsi_switch
  import tsi_pkg::*;
#(
  parameter int NS_IN  = 4,
  parameter int NS_OUT = 4,
  parameter int CH_HI  = 128,
  localparam int SIW = $clog2(NS_IN),
  localparam int SOW = $clog2(NS_OUT),
  localparam int CHW = $clog2(CH_HI),
  localparam int CW  = CHW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic [1:0]        rate_in_lo,
  input  logic [1:0]        rate_in_hi,
  input  logic [1:0]        rate_out_lo,
  input  logic [1:0]        rate_out_hi,
  input  logic              drive_pin,
  input  logic              drive_cfg,
  input  logic [NS_IN-1:0]  ser_in,
  input  logic              cm_we,
  input  logic [SOW-1:0]    cm_stream,
  input  logic [CHW-1:0]    cm_chan,
  input  logic [SIW-1:0]    cm_src_stream,
  input  logic [CHW-1:0]    cm_src_chan,
  input  logic              cm_hiz,
  input  logic              cm_ctl,
  output logic [NS_OUT-1:0] ser_out,
  output logic [NS_OUT-1:0] ser_oe,
  output logic              ctl_out
);

  logic [CW-1:0]               frm_cnt;
  logic                        frm_par;
  logic [CW-1:0]               frm_cnt_nxt;
  logic                        frm_par_nxt;
  logic [NS_OUT-1:0][CHW-1:0]  slot_chan;
  logic [NS_OUT-1:0][SIW-1:0]  src_st;
  logic [NS_OUT-1:0][CHW-1:0]  src_ch;
  logic [NS_OUT-1:0]           slot_hiz;
  logic [NS_OUT-1:0][7:0]      slot_byte;
  logic                        ctl_bit;

  tsi_frame_timer #(.CW(CW)) u_tim (
    .clk     (clk),
    .rst_n   (rst_n),
    .fp      (frame_pulse),
    .cnt_q   (frm_cnt),
    .par_q   (frm_par),
    .cnt_nxt (frm_cnt_nxt),
    .par_nxt (frm_par_nxt)
  );

  tsi_rx_store #(.NS_IN(NS_IN), .NS_OUT(NS_OUT), .CH_HI(CH_HI)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_q     (frm_cnt),
    .par_q     (frm_par),
    .rate_lo   (rate_in_lo),
    .rate_hi   (rate_in_hi),
    .ser_in    (ser_in),
    .rd_bank   (~frm_par_nxt),
    .rd_stream (src_st),
    .rd_chan   (src_ch),
    .rd_data   (slot_byte)
  );

  tsi_conn_mem #(.NS_IN(NS_IN), .NS_OUT(NS_OUT), .CH_HI(CH_HI)) u_cm (
    .clk       (clk),
    .we        (cm_we),
    .wr_stream (cm_stream),
    .wr_chan   (cm_chan),
    .wr_src_st (cm_src_stream),
    .wr_src_ch (cm_src_chan),
    .wr_hiz    (cm_hiz),
    .wr_ctl    (cm_ctl),
    .rd_chan   (slot_chan),
    .ctl_idx   (frm_cnt_nxt),
    .rd_src_st (src_st),
    .rd_src_ch (src_ch),
    .rd_hiz    (slot_hiz),
    .ctl_bit   (ctl_bit)
  );

  tsi_tx_serial #(.NS_OUT(NS_OUT), .CH_HI(CH_HI)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_nxt   (frm_cnt_nxt),
    .rate_lo   (rate_out_lo),
    .rate_hi   (rate_out_hi),
    .drive_en  (drive_pin | drive_cfg),
    .byte_in   (slot_byte),
    .hiz_in    (slot_hiz),
    .ctl_in    (ctl_bit),
    .slot_chan (slot_chan),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe),
    .ctl_out   (ctl_out)
  );

endmodule

// File: rtl/tdm_tsi_switch_chk.sv
module tdm_tsi_switch_chk #(
  parameter int NS_OUT    = 4,
  parameter int CW        = 11,
  parameter int CTL_SLOTS = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fp,
  input logic [CW-1:0]     cnt,
  input logic              par,
  input logic              drive_pin,
  input logic              drive_cfg,
  input logic [NS_OUT-1:0] ser_out,
  input logic [NS_OUT-1:0] ser_oe,
  input logic              ctl_out
);

  p_quiet_at_release_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ser_oe == '0 && ser_out == '0 && !ctl_out && cnt == '0));

  p_pulse_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (cnt == '0));

  p_wrap_new_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt) && !fp) |=> (cnt == '0 && par != $past(par)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp && !(&cnt)) |=> (cnt == $past(cnt) + CW'(1) && par == $past(par)));

  p_drive_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_pin && !drive_cfg) |=> (ser_oe == '0));

  p_ctl_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) >= CTL_SLOTS) |-> !ctl_out);

endmodule

bind tdm_tsi_switch tdm_tsi_switch_chk #(
  .NS_OUT    (NS_OUT),
  .CW        (CW),
  .CTL_SLOTS (NS_OUT * CH_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fp        (frame_pulse),
  .cnt       (frm_cnt),
  .par       (frm_par),
  .drive_pin (drive_pin),
  .drive_cfg (drive_cfg),
  .ser_out   (ser_out),
  .ser_oe    (ser_oe),
  .ctl_out   (ctl_out)
);

// File: tb/tdm_tsi_switch_tb.sv
module tdm_tsi_switch_tb;

  localparam int NI = 4;
  localparam int NO = 4;
  localparam int CH = 16;
  localparam int FR = CH * 16;

  logic          clk;
  logic          rst_n;
  logic          frame_pulse;
  logic [1:0]    rate_in_lo, rate_in_hi, rate_out_lo, rate_out_hi;
  logic          drive_pin, drive_cfg;
  logic [NI-1:0] ser_in;
  logic          cm_we;
  logic [1:0]    cm_stream;
  logic [3:0]    cm_chan;
  logic [1:0]    cm_src_stream;
  logic [3:0]    cm_src_chan;
  logic          cm_hiz, cm_ctl;
  logic [NO-1:0] ser_out, ser_oe;
  logic          ctl_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_ss [NO][CH];
  int m_sc [NO][CH];
  int m_h  [NO][CH];
  int m_ct [NO][CH];

  tdm_tsi_switch #(.NS_IN(NI), .NS_OUT(NO), .CH_HI(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .rate_in_lo(rate_in_lo), .rate_in_hi(rate_in_hi),
    .rate_out_lo(rate_out_lo), .rate_out_hi(rate_out_hi),
    .drive_pin(drive_pin), .drive_cfg(drive_cfg), .ser_in(ser_in),
    .cm_we(cm_we), .cm_stream(cm_stream), .cm_chan(cm_chan),
    .cm_src_stream(cm_src_stream), .cm_src_chan(cm_src_chan),
    .cm_hiz(cm_hiz), .cm_ctl(cm_ctl),
    .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int lg_of(input int code);
    return (code == 0) ? 3 : (code == 1) ? 2 : 1;
  endfunction

  function automatic int nch_of(input int code);
    return CH >> (lg_of(code) - 1);
  endfunction

  function automatic int pat(input int f, input int s, input int c);
    return (f * 37 + s * 11 + c * 5 + 3) & 255;
  endfunction

  function automatic int in_code(input int s);
    return (s < NI / 2) ? int'(rate_in_lo) : int'(rate_in_hi);
  endfunction

  function automatic int out_code(input int o);
    return (o < NO / 2) ? int'(rate_out_lo) : int'(rate_out_hi);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: write every connection word through the port, mirror it locally
  task automatic load_map(input int r);
    for (int o = 0; o < NO; o++) begin
      for (int c = 0; c < CH; c++) begin
        int ss = (o + c + r) % NI;
        int n  = nch_of(in_code(ss));
        m_ss[o][c] = ss;
        m_sc[o][c] = n - 1 - ((c * 3 + o + r) % n);
        m_h[o][c]  = ((c + o + r) % 5 == 4) ? 1 : 0;
        m_ct[o][c] = ((c * 7 + o + r) % 3 == 0) ? 1 : 0;
        @(negedge clk);
        cm_we = 1'b1;
        cm_stream = 2'(o);
        cm_chan = 4'(c);
        cm_src_stream = 2'(m_ss[o][c]);
        cm_src_chan = 4'(m_sc[o][c]);
        cm_hiz = 1'(m_h[o][c]);
        cm_ctl = 1'(m_ct[o][c]);
      end
    end
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  task automatic run(input int nframes, input bit pulse_each);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
    for (int f = 0; f < nframes; f++) begin
      for (int k = 0; k < FR; k++) begin
        bit drv = drive_pin | drive_cfg;
        for (int s = 0; s < NI; s++) begin
          int l = lg_of(in_code(s));
          int b = k >> l;
          ser_in[s] = 1'((pat(f, s, b >> 3) >> (7 - (b & 7))) & 1);
        end
        for (int o = 0; o < NO; o++) begin
          int l  = lg_of(out_code(o));
          int c  = k >> (l + 3);
          int bt = (k >> l) & 7;
          int eoe = (drv && m_h[o][c] == 0) ? 1 : 0;
          chk(ser_oe[o] == 1'(eoe), "R6 R7 R9 output enable", int'(ser_oe[o]), eoe);
          if (f >= 1 && eoe == 1) begin
            int eb = (pat(f - 1, m_ss[o][c], m_sc[o][c]) >> (7 - bt)) & 1;
            int last = nch_of(in_code(m_ss[o][c])) - 1;
            if (c == 0 && m_sc[o][c] == last)
              chk(ser_out[o] == 1'(eb), "R10 frame-edge forward", int'(ser_out[o]), eb);
            else
              chk(ser_out[o] == 1'(eb), "R2 R3 R4 R5 switched bit", int'(ser_out[o]), eb);
          end
        end
        begin
          int ect = (k < NO * CH) ? m_ct[k % NO][k / NO] : 0;
          chk(ctl_out == 1'(ect), "R8 control stream", int'(ctl_out), ect);
        end
        frame_pulse = (pulse_each && k == FR - 1);
        @(negedge clk);
      end
    end
    frame_pulse = 1'b0;
  endtask

  task automatic set_cfg(input int il, input int ih, input int ol, input int oh,
                         input bit dp, input bit dc);
    rate_in_lo = 2'(il);
    rate_in_hi = 2'(ih);
    rate_out_lo = 2'(ol);
    rate_out_hi = 2'(oh);
    drive_pin = dp;
    drive_cfg = dc;
  endtask

  initial begin
    rst_n = 1'b0;
    frame_pulse = 1'b0;
    ser_in = '0;
    cm_we = 1'b0;
    cm_stream = '0;
    cm_chan = '0;
    cm_src_stream = '0;
    cm_src_chan = '0;
    cm_hiz = 1'b0;
    cm_ctl = 1'b0;
    set_cfg(2, 2, 2, 2, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ser_oe == '0, "R1 reset enable", int'(ser_oe), 0);
      chk(ser_out == '0, "R1 reset data", int'(ser_out), 0);
      chk(ctl_out == 1'b0, "R1 reset control", int'(ctl_out), 0);
    end
    rst_n = 1'b1;

    // single-rate, pulse at every frame boundary
    set_cfg(2, 2, 2, 2, 1'b1, 1'b0);
    load_map(0);
    run(3, 1'b1);

    // mixed rates incl. code 3, free-running wrap
    set_cfg(0, 3, 1, 2, 1'b0, 1'b1);
    load_map(1);
    run(3, 1'b0);

    // both drive enables low
    set_cfg(1, 0, 0, 1, 1'b0, 1'b0);
    load_map(2);
    run(2, 1'b0);

    // other mixed rates, both enables high
    set_cfg(2, 1, 2, 0, 1'b1, 1'b1);
    load_map(3);
    run(3, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule